// File: doc/BRIEF.md
# Consecutive-Fault Window Alarm

This block watches a single 10-bit measurement channel over successive conversion scans. Each averaged result arrives on a valid/ready sample stream. The block compares it with a programmable upper limit and a programmable lower limit. A result above the upper limit is a high fault. A result below the lower limit is a low fault. A result equal to either limit counts as in range.

The block counts consecutive faults that break the same limit. The count returns to zero when a result lands back inside the window. When a fault breaks the opposite limit, the count restarts at one on the new side. When the count reaches the programmed fault setting plus one, the block latches a side-specific alarm and an interrupt. These stay set until an explicit clear.

The fault setting is held in an internal register. It loads on a write strobe and returns to zero on power-up reset and on the soft reset input. The sample port always accepts data, except while soft reset is held. During soft reset, ready is low and any offered sample is ignored. An upstream producer must hold its sample until it sees valid and ready high together on a clock edge.

Top module: `fltmon_top`

## Requirements
- R1: After `rst_n` is released, `alarm_hi`, `alarm_lo` and `irq` are 0, the stored fault setting is 0 and the count is 0.
- R2: A sample with `thr_lo <= smp_data <= thr_hi` is in range (equality included). It raises no alarm and returns the count to zero.
- R3: A sample above `thr_hi` is a high fault, and a sample below `thr_lo` is a low fault. Consecutive accepted faults on the same side add one each to the count.
- R4: With a stored 4-bit unsigned setting N (0 to 15), the alarm is raised on the accepted fault that brings the count to N+1. With N = 0, the first fault raises it.
- R5: A fault on the opposite side from the previous fault restarts the count at 1 on the new side, instead of adding to it.
- R6: The alarm that is set matches the side of the fault that set it: `alarm_hi` for high, `alarm_lo` for low. `irq` is 1 whenever either alarm is 1.
- R7: Alarms and `irq` stay latched until `alarm_clr`. When `alarm_clr` and an alarm-raising fault fall in the same cycle, the new alarm is set and older alarms are cleared. `alarm_clr` does not change the count.
- R8: The count saturates at 2^CNT_W-1 (31 by default) instead of wrapping. Each further same-side fault at or beyond N+1 raises the alarm again after a clear.
- R9: `soft_rst` clears the count, the side, the alarms, `irq` and the stored setting to 0. While it is high, `smp_ready` is 0.
- R10: `cfg_fault_n` is stored only in a cycle with `cfg_we` = 1. Otherwise its value has no effect.
- R11: A sample is taken only on a clock edge with `smp_valid` and `smp_ready` both 1. `smp_ready` depends only on `soft_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of count, alarms and setting |
| alarm_clr | input | 1 | Clears the latched alarms and interrupt |
| cfg_we | input | 1 | Write strobe for the fault setting |
| cfg_fault_n | input | 4 | Fault setting N; the alarm fires at N+1 faults |
| thr_hi | input | 10 | Upper window limit (inclusive) |
| thr_lo | input | 10 | Lower window limit (inclusive) |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample can be taken |
| smp_data | input | 10 | Averaged sample value |
| alarm_hi | output | 1 | Latched high-side alarm |
| alarm_lo | output | 1 | Latched low-side alarm |
| irq | output | 1 | Latched interrupt, set with either alarm |

## Verification
Two functions can fall in the same cycle. One is the alarm clear. The other is a sample that itself completes the fault run. The bench latches a low alarm, then drives `alarm_clr` in the very cycle that a high fault is offered with a setting of zero. The expected result is `alarm_hi` and `irq` set and `alarm_lo` cleared. A second collision puts a soft reset and a valid fault sample in the same cycle. There, the reset must win and the sample must leave no trace.

// File: rtl/fltmon_pkg.sv
package fltmon_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE = 2'b00,
    SIDE_HI   = 2'b01,
    SIDE_LO   = 2'b10
  } side_e;
endpackage

// File: rtl/fltmon_cmp.sv
// Window comparator: classifies one sample against the inclusive limits.
module fltmon_cmp
  import fltmon_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] lim_hi,
  input  logic [DW-1:0] lim_lo,
  output side_e         side
);
  always_comb begin
    if (data > lim_hi)      side = SIDE_HI;
    else if (data < lim_lo) side = SIDE_LO;
    else                    side = SIDE_NONE;
  end
endmodule

// File: rtl/fltmon_cnt.sv
// Same-side run counter with saturation and side memory.
module fltmon_cnt
  import fltmon_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  side_e            side_in,
  output logic [CNT_W-1:0] cnt_q,
  output side_e            side_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output side_e            side_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    cnt_nxt  = cnt_q;
    side_nxt = side_q;
    if (clear) begin
      cnt_nxt  = '0;
      side_nxt = SIDE_NONE;
    end else if (step) begin
      if (side_in == SIDE_NONE) begin
        cnt_nxt  = '0;
        side_nxt = SIDE_NONE;
      end else if (side_in == side_q) begin
        cnt_nxt  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
      end else begin
        cnt_nxt  = {{(CNT_W-1){1'b0}}, 1'b1};
        side_nxt = side_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      side_q <= SIDE_NONE;
    end else begin
      cnt_q  <= cnt_nxt;
      side_q <= side_nxt;
    end
  end
endmodule

// File: rtl/fltmon_alarm.sv
// Latched per-side alarms and interrupt; a new event beats a clear.
module fltmon_alarm
  import fltmon_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  ack,
  input  logic  fire,
  input  side_e fire_side,
  output logic  alarm_hi,
  output logic  alarm_lo,
  output logic  irq
);
  localparam int NSIDE = 2;
  logic [NSIDE-1:0] flag_q;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam side_e MY_SIDE = (s == 0) ? SIDE_HI : SIDE_LO;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                flag_q[s] <= 1'b0;
      else if (clear)                            flag_q[s] <= 1'b0;
      else if (fire && (fire_side == MY_SIDE))   flag_q[s] <= 1'b1;
      else if (ack)                              flag_q[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq <= 1'b0;
    else if (clear) irq <= 1'b0;
    else if (fire)  irq <= 1'b1;
    else if (ack)   irq <= 1'b0;
  end

  assign alarm_hi = flag_q[0];
  assign alarm_lo = flag_q[1];
endmodule

// File: rtl/fltmon_top.sv
module fltmon_top
  import fltmon_pkg::*;
#(
  parameter int DW    = 10,
  parameter int FLT_W = 4,
  parameter int CNT_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            alarm_clr,
  input  logic            cfg_we,
  input  logic [FLT_W-1:0] cfg_fault_n,
  input  logic [DW-1:0]   thr_hi,
  input  logic [DW-1:0]   thr_lo,
  input  logic            smp_valid,
  output logic            smp_ready,
  input  logic [DW-1:0]   smp_data,
  output logic            alarm_hi,
  output logic            alarm_lo,
  output logic            irq
);
  localparam int PAD_W = CNT_W - FLT_W;

  logic [FLT_W-1:0] cfg_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  side_e            side_q, side_nxt, smp_side;
  logic             accept, fire;

  assign smp_ready = ~soft_rst;
  assign accept    = smp_valid & smp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (soft_rst) cfg_q <= '0;
    else if (cfg_we)   cfg_q <= cfg_fault_n;
  end

  assign limit = {{PAD_W{1'b0}}, cfg_q} + 1'b1;

  fltmon_cmp #(.DW(DW)) u_cmp (
    .data   (smp_data),
    .lim_hi (thr_hi),
    .lim_lo (thr_lo),
    .side   (smp_side)
  );

  fltmon_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (soft_rst),
    .step     (accept),
    .side_in  (smp_side),
    .cnt_q    (cnt_q),
    .side_q   (side_q),
    .cnt_nxt  (cnt_nxt),
    .side_nxt (side_nxt)
  );

  assign fire = accept && (smp_side != SIDE_NONE) && (cnt_nxt >= limit);

  fltmon_alarm u_alarm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (soft_rst),
    .ack       (alarm_clr),
    .fire      (fire),
    .fire_side (side_nxt),
    .alarm_hi  (alarm_hi),
    .alarm_lo  (alarm_lo),
    .irq       (irq)
  );
endmodule

// File: rtl/fltmon_chk.sv
module fltmon_chk
  import fltmon_pkg::*;
#(
  parameter int DW    = 10,
  parameter int FLT_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             alarm_clr,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [DW-1:0]    smp_data,
  input logic [DW-1:0]    thr_hi,
  input logic [DW-1:0]    thr_lo,
  input logic [FLT_W-1:0] cfg_q,
  input logic [CNT_W-1:0] cnt_q,
  input side_e            side_q,
  input logic             alarm_hi,
  input logic             alarm_lo,
  input logic             irq
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic tk;
  assign tk = smp_valid && smp_ready;

  p_irq_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (alarm_hi || alarm_lo));

  p_latch_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hi && !alarm_clr && !soft_rst) |=> alarm_hi);

  p_latch_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_lo && !alarm_clr && !soft_rst) |=> alarm_lo);

  p_inrange_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && smp_data <= thr_hi && smp_data >= thr_lo && !alarm_clr)
      |=> ($stable(alarm_hi) && $stable(alarm_lo) && cnt_q == '0));

  p_first_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && cfg_q == '0 && smp_data > thr_hi) |=> alarm_hi);

  p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq && !alarm_hi && !alarm_lo && cnt_q == '0 && cfg_q == '0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && cnt_q == CMAX && side_q == SIDE_HI && smp_data > thr_hi)
      |=> cnt_q == CMAX);

  p_side_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(side_q) && ((side_q == SIDE_NONE) == (cnt_q == '0)));
endmodule

bind fltmon_top fltmon_chk #(.DW(DW), .FLT_W(FLT_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_fltmon_top.sv
module tb_fltmon_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, alarm_clr = 1'b0, cfg_we = 1'b0;
  logic [3:0] cfg_fault_n = 4'd0;
  logic [9:0] thr_hi = 10'd600, thr_lo = 10'd200;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [9:0] smp_data = 10'd0;
  logic       alarm_hi, alarm_lo, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fltmon_top dut (.*);

  // vector: {data[9:0], exp alarm_hi, exp alarm_lo, exp irq}; limits 600/200, N=2
  localparam logic [12:0] VEC [0:10] = '{
    {10'd400,  3'b000}, {10'd700, 3'b000}, {10'd700, 3'b000},
    {10'd100,  3'b000}, {10'd100, 3'b000}, {10'd600, 3'b000},
    {10'd200,  3'b000}, {10'd601, 3'b000}, {10'd650, 3'b000},
    {10'd1023, 3'b101}, {10'd400, 3'b101}
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: hi/lo/irq actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] d);
    @(negedge clk); smp_valid = 1'b1; smp_data = d;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [3:0] n);
    @(negedge clk); cfg_fault_n = n; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0;
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  function automatic logic [2:0] outs();
    return {alarm_hi, alarm_lo, irq};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", outs(), 3'b000);
    check("R11 ready after reset", {2'b00, smp_ready}, 3'b001);
    // R1: stored setting 0 after reset -> first fault alarms
    send(10'd900);
    check("R1 setting zero at reset", outs(), 3'b101);
    pulse_clr();
    check("R7 clear drops alarm", outs(), 3'b000);

    // vector walk, N=2: R2 R3 R4 R5 R6
    pulse_soft();
    set_cfg(4'd2);
    for (int i = 0; i < 11; i++) begin
      send(VEC[i][12:3]);
      check($sformatf("R2 R3 R4 R5 R6 vector %0d", i), outs(), VEC[i][2:0]);
    end

    // R5: opposite side restarts at 1, N=1
    pulse_soft();
    set_cfg(4'd1);
    send(10'd700); send(10'd100); send(10'd700);
    check("R5 alternating sides no alarm", outs(), 3'b000);
    send(10'd700);
    check("R5 second same-side fault alarms", outs(), 3'b101);
    pulse_clr();
    send(10'd50);
    check("R5 opposite after run restarts", outs(), 3'b000);
    send(10'd50);
    check("R6 low alarm side", outs(), 3'b011);

    // R7: clear and fault in the same cycle, N=0
    pulse_soft();
    send(10'd10);
    check("R7 low alarm latched", outs(), 3'b011);
    send(10'd400);
    check("R7 alarm held across in-range", outs(), 3'b011);
    @(negedge clk); alarm_clr = 1'b1; smp_valid = 1'b1; smp_data = 10'd900;
    @(negedge clk); alarm_clr = 1'b0; smp_valid = 1'b0;
    check("R7 set wins over clear", outs(), 3'b101);

    // R8: saturation, N=15
    pulse_soft();
    set_cfg(4'd15);
    for (int i = 0; i < 15; i++) send(10'd800);
    check("R4 no alarm at 15 faults", outs(), 3'b000);
    send(10'd800);
    check("R4 alarm at 16 faults", outs(), 3'b101);
    for (int i = 0; i < 24; i++) send(10'd800);
    pulse_clr();
    check("R8 clear after long run", outs(), 3'b000);
    send(10'd800);
    check("R8 saturated count re-alarms", outs(), 3'b101);

    // R10: setting input ignored without write strobe
    pulse_soft();
    set_cfg(4'd0);
    @(negedge clk); cfg_fault_n = 4'd9;
    send(10'd700);
    check("R10 unwritten setting ignored", outs(), 3'b101);

    // R9 / R11: soft reset collides with a valid fault
    @(negedge clk); soft_rst = 1'b1; smp_valid = 1'b1; smp_data = 10'd900;
    #1 check("R9 ready low in soft reset", {2'b00, smp_ready}, 3'b000);
    @(negedge clk); soft_rst = 1'b0; smp_valid = 1'b0;
    check("R9 soft reset clears alarms", outs(), 3'b000);
    @(negedge clk); smp_data = 10'd900;
    @(negedge clk);
    check("R11 no take without valid", outs(), 3'b000);
    send(10'd900);
    check("R9 setting back to zero", outs(), 3'b101);

    finish_run();
  end
endmodule